// File: doc/BRIEF.md
# Triggered Sample Capture Controller

The block sits between a dual-channel 14-bit ADC stream and a circular sample store. It takes one sample per channel on every clock and thins the stream with a decimator. The decimator keeps either the last sample of each window or the mean of the whole window. An arm command starts writing decimated samples to the store. The block then waits for a trigger from one selected source. Once the trigger is accepted, it writes a programmed number of further samples, stops, and raises a completion flag.

The store is external. The block drives a write strobe, an address and one data word per channel. It also outputs the running write pointer, the pointer captured at the trigger, and its capture phase. Software uses the trigger pointer and the post-trigger length to find the pre-trigger and post-trigger parts of the record in the wrapped buffer.

Top module: `trig_capture`

## Requirements
- R1: While `rst_n` is low, and after it is released with no commands, `wr_en`, `wp_cur`, `wp_trig`, `post_done` and `cap_state` are all zero.
- R2: `dec_code` values 0 to 5 select decimation ratios of 1, 8, 64, 1024, 8192 and 65536. Codes 6 and 7 act as ratio 1. After an arm, the first decimated sample appears after exactly one full window of input samples.
- R3: With `avg_en` low, each decimated value is the last input sample of its window.
- R4: With `avg_en` high, each decimated value is the window sum shifted arithmetically right by log2 of the ratio (the floor of the mean). A full 65536-sample window at either ADC extreme gives the extreme value back, with no overflow.
- R5: Decimated samples are written only in the capture phases ARMED (`cap_state`=1) and POST (`cap_state`=2). Each write goes to address `wp_cur`, and `wp_cur` then advances by one modulo 16384. An arm sets `wp_cur` and `wp_trig` to 0.
- R6: Triggers are ignored outside ARMED, and only the first accepted trigger after an arm counts. On acceptance, `wp_trig` captures `wp_cur`, which is the address of the sample written in the same cycle, if there is one.
- R7: A channel rising trigger (`trig_src` 1 for A, 3 for B) fires on a decimated sample at or above the threshold. It fires only if an earlier decimated sample since the arm was at or below threshold minus hysteresis, with no rising fire in between.
- R8: A channel falling trigger (`trig_src` 2 for A, 4 for B) mirrors R7. The qualifying level is threshold plus hysteresis, and it fires at or below the threshold.
- R9: `trig_src` 5 and 6 select a rising or falling edge of `ext_trig`, passed through a two-stage synchronizer. `trig_src` 7 and 8 select a rising or falling edge of `gen_evt`, which is registered once. `trig_src` 0 triggers on the first ARMED cycle.
- R10: After the trigger, exactly `post_len` further decimated samples are written. The block then enters DONE (`cap_state`=3, `post_done` high) and writes nothing more. With `post_len` 0 it goes to DONE straight from the trigger cycle.
- R11: `cmd_reset` returns the block to IDLE (`cap_state`=0) on the next edge and stops writing. It takes priority over a simultaneous `cmd_arm`.
- R12: `trig_src` values 9 to 15 never trigger. Capture then keeps running and the pointer wraps through the whole buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one ADC sample per channel per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_arm | input | 1 | One-cycle pulse: restart the decimator and start capture |
| cmd_reset | input | 1 | One-cycle pulse: return to IDLE |
| trig_src | input | 4 | Trigger source code (R7, R8, R9, R12) |
| dec_code | input | 3 | Decimation ratio code (R2) |
| avg_en | input | 1 | Window averaging enable |
| thr_a | input | 14 | Channel A threshold, two's complement |
| thr_b | input | 14 | Channel B threshold, two's complement |
| hyst_a | input | 14 | Channel A hysteresis, unsigned |
| hyst_b | input | 14 | Channel B hysteresis, unsigned |
| post_len | input | 32 | Decimated samples written after the trigger |
| adc_a | input | 14 | Channel A sample, two's complement |
| adc_b | input | 14 | Channel B sample, two's complement |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| gen_evt | input | 1 | Synchronous event from the signal generator |
| wr_en | output | 1 | Store write strobe |
| wr_addr | output | 14 | Store write address |
| wr_data_a | output | 14 | Decimated channel A sample |
| wr_data_b | output | 14 | Decimated channel B sample |
| wp_cur | output | 14 | Next write address |
| wp_trig | output | 14 | Write pointer captured at the trigger |
| cap_state | output | 2 | Phase: 0 IDLE, 1 ARMED, 2 POST, 3 DONE |
| post_done | output | 1 | High once the post-trigger count has run out |

## Verification
The assertions assume three things about the inputs:
- `cmd_arm` and `cmd_reset` are single-cycle pulses.
- The configuration inputs stay constant from an arm until the following reset command.
- `ext_trig` and `gen_evt` are low when reset is released, so the edge history starts clean.

The stimulus respects all three. It changes configuration only in IDLE, gives every command a one-cycle pulse driven on the falling clock edge, and toggles the event inputs only after reset. Within those limits, the ADC patterns cover a triangle that crosses each threshold in both directions, a pseudo-random stream and constant full-scale values. Together these reach every trigger source and every averaging path.

// File: rtl/cap_pkg.sv
// Shared types and helpers for the triggered capture controller.
// Assumes: decimation ratios are powers of two up to 2**DEC_MAX_SHIFT.
package cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_e;

    localparam int DEC_MAX_SHIFT = 16;
    localparam int SRC_W         = 4;

    localparam logic [SRC_W-1:0] SRC_NOW    = 4'd0;
    localparam logic [SRC_W-1:0] SRC_A_UP   = 4'd1;
    localparam logic [SRC_W-1:0] SRC_A_DN   = 4'd2;
    localparam logic [SRC_W-1:0] SRC_B_UP   = 4'd3;
    localparam logic [SRC_W-1:0] SRC_B_DN   = 4'd4;
    localparam logic [SRC_W-1:0] SRC_EXT_UP = 4'd5;
    localparam logic [SRC_W-1:0] SRC_EXT_DN = 4'd6;
    localparam logic [SRC_W-1:0] SRC_GEN_UP = 4'd7;
    localparam logic [SRC_W-1:0] SRC_GEN_DN = 4'd8;

    // Map a ratio code to log2 of the decimation ratio; unknown codes mean ratio 1.
    function automatic logic [4:0] ratio_shift(input logic [2:0] code);
        case (code)
            3'd1:    return 5'd3;
            3'd2:    return 5'd6;
            3'd3:    return 5'd10;
            3'd4:    return 5'd13;
            3'd5:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/cap_decimator.sv
// Decimator for NCH channels of DATA_W-bit signed samples, one sample per clock.
// Emits one sample per window of 2**shift inputs: either the last sample of the
// window or the floor of the window mean. A restart clears the window.
// Assumes: dec_code and avg_en are stable while a capture runs.
module cap_decimator
    import cap_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int NCH    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic [2:0]            dec_code,
    input  logic                  avg_en,
    input  logic [NCH*DATA_W-1:0] smp_in,
    output logic                  dec_valid,
    output logic [NCH*DATA_W-1:0] dec_data
);

    localparam int CNT_W = DEC_MAX_SHIFT;
    localparam int ACC_W = DATA_W + DEC_MAX_SHIFT;

    logic [4:0]       shamt;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] cnt;
    logic             win_end;

    assign shamt    = ratio_shift(dec_code);
    assign last_idx = ~({CNT_W{1'b1}} << shamt);
    assign win_end  = (cnt == last_idx);

    // Position inside the current window.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)  cnt <= '0;
        else if (win_end)       cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    // One-cycle strobe for each finished window.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)  dec_valid <= 1'b0;
        else                    dec_valid <= win_end;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic signed [DATA_W-1:0] x;
        logic signed [ACC_W-1:0]  x_ext;
        logic signed [ACC_W-1:0]  acc;
        logic signed [ACC_W-1:0]  sum;

        assign x     = $signed(smp_in[c*DATA_W +: DATA_W]);
        assign x_ext = {{DEC_MAX_SHIFT{x[DATA_W-1]}}, x};
        assign sum   = acc + x_ext;

        // Running window sum, cleared at each window end.
        always_ff @(posedge clk) begin
            if (!rst_n || restart)  acc <= '0;
            else if (win_end)       acc <= '0;
            else                    acc <= sum;
        end

        // Window result: mean or last sample.
        always_ff @(posedge clk) begin
            if (!rst_n)             dec_data[c*DATA_W +: DATA_W] <= '0;
            else if (win_end)       dec_data[c*DATA_W +: DATA_W] <= avg_en ? DATA_W'(sum >>> shamt) : x;
        end
    end

endmodule

// File: rtl/cap_trig_detect.sv
// Trigger source selection. Level triggers compare decimated samples against a
// threshold with a hysteresis qualifier. The external pin passes through a two-stage
// synchronizer; the generator event is registered once. Output fire is combinational.
// Assumes: thresholds are two's complement and hysteresis is unsigned.
module cap_trig_detect
    import cap_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic [SRC_W-1:0]    trig_src,
    input  logic [2*DATA_W-1:0] thr_flat,
    input  logic [2*DATA_W-1:0] hyst_flat,
    input  logic                dec_valid,
    input  logic [2*DATA_W-1:0] dec_data,
    input  logic                ext_trig,
    input  logic                gen_evt,
    output logic                fire
);

    localparam int CMP_W = DATA_W + 2;

    logic [1:0] up_hit;
    logic [1:0] dn_hit;
    logic       ext_s1, ext_s2, ext_s3;
    logic       gen_q1, gen_q2;

    for (genvar c = 0; c < 2; c++) begin : g_lvl
        logic signed [CMP_W-1:0] s, t, lo, hi;
        logic                    up_rdy, dn_rdy;

        assign s  = {{2{dec_data[c*DATA_W+DATA_W-1]}}, dec_data[c*DATA_W +: DATA_W]};
        assign t  = {{2{thr_flat[c*DATA_W+DATA_W-1]}}, thr_flat[c*DATA_W +: DATA_W]};
        assign lo = t - {2'b00, hyst_flat[c*DATA_W +: DATA_W]};
        assign hi = t + {2'b00, hyst_flat[c*DATA_W +: DATA_W]};

        assign up_hit[c] = dec_valid && up_rdy && (s >= t);
        assign dn_hit[c] = dec_valid && dn_rdy && (s <= t);

        // Qualifier for a rising crossing: set below the low level, spent when the threshold is reached.
        always_ff @(posedge clk) begin
            if (!rst_n || restart)  up_rdy <= 1'b0;
            else if (dec_valid)     up_rdy <= (s <= lo) ? 1'b1 : ((s >= t) ? 1'b0 : up_rdy);
        end

        // Qualifier for a falling crossing: set above the high level, spent when the threshold is reached.
        always_ff @(posedge clk) begin
            if (!rst_n || restart)  dn_rdy <= 1'b0;
            else if (dec_valid)     dn_rdy <= (s >= hi) ? 1'b1 : ((s <= t) ? 1'b0 : dn_rdy);
        end
    end

    // Synchronize the external pin and keep one cycle of history for both event inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ext_s1, ext_s2, ext_s3} <= '0;
            {gen_q1, gen_q2}         <= '0;
        end else begin
            ext_s1 <= ext_trig;
            ext_s2 <= ext_s1;
            ext_s3 <= ext_s2;
            gen_q1 <= gen_evt;
            gen_q2 <= gen_q1;
        end
    end

    // Pick the selected trigger condition.
    always_comb begin
        case (trig_src)
            SRC_NOW:    fire = 1'b1;
            SRC_A_UP:   fire = up_hit[0];
            SRC_A_DN:   fire = dn_hit[0];
            SRC_B_UP:   fire = up_hit[1];
            SRC_B_DN:   fire = dn_hit[1];
            SRC_EXT_UP: fire = ext_s2 && !ext_s3;
            SRC_EXT_DN: fire = !ext_s2 && ext_s3;
            SRC_GEN_UP: fire = gen_q1 && !gen_q2;
            SRC_GEN_DN: fire = !gen_q1 && gen_q2;
            default:    fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/cap_fsm.sv
// Capture sequencer. It writes decimated samples to a circular store while ARMED
// or POST, captures the write pointer at the first accepted trigger, and counts
// post-trigger writes down to DONE.
// Assumes: commands are single-cycle pulses and post_len is stable while armed.
module cap_fsm
    import cap_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int ADDR_W = 14,
    parameter int LEN_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_arm,
    input  logic                cmd_reset,
    input  logic                fire,
    input  logic [LEN_W-1:0]    post_len,
    input  logic                dec_valid,
    input  logic [2*DATA_W-1:0] dec_data,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [2*DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0]   wp_cur,
    output logic [ADDR_W-1:0]   wp_trig,
    output cap_state_e          state
);

    logic [LEN_W-1:0] remaining;
    logic             capturing;
    logic             do_write;

    assign capturing = (state == ST_ARMED) || (state == ST_POST);
    assign do_write  = capturing && dec_valid && !cmd_reset && !cmd_arm;

    // Write port and circular pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wp_cur  <= '0;
        end else begin
            wr_en <= do_write;
            if (do_write) begin
                wr_addr <= wp_cur;
                wr_data <= dec_data;
                wp_cur  <= wp_cur + 1'b1;
            end else if (cmd_arm && !cmd_reset) begin
                wp_cur  <= '0;
            end
        end
    end

    // Phase sequencing, trigger pointer capture and post-trigger countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            wp_trig   <= '0;
            remaining <= '0;
        end else if (cmd_reset) begin
            state     <= ST_IDLE;
        end else if (cmd_arm) begin
            state     <= ST_ARMED;
            wp_trig   <= '0;
        end else begin
            case (state)
                ST_ARMED: if (fire) begin
                    wp_trig <= wp_cur;
                    if (post_len == '0) begin
                        state     <= ST_DONE;
                    end else begin
                        remaining <= post_len;
                        state     <= ST_POST;
                    end
                end
                ST_POST: if (dec_valid) begin
                    remaining <= remaining - 1'b1;
                    if (remaining == LEN_W'(1)) state <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/trig_capture.sv
// Top of the triggered capture controller: decimator, trigger detector and
// capture sequencer for two ADC channels.
// Assumes: one new sample per channel on every clock, and an external store
// of 2**ADDR_W words driven by wr_en, wr_addr and the data outputs.
module trig_capture
    import cap_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int ADDR_W = 14,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_arm,
    input  logic              cmd_reset,
    input  logic [3:0]        trig_src,
    input  logic [2:0]        dec_code,
    input  logic              avg_en,
    input  logic [DATA_W-1:0] thr_a,
    input  logic [DATA_W-1:0] thr_b,
    input  logic [DATA_W-1:0] hyst_a,
    input  logic [DATA_W-1:0] hyst_b,
    input  logic [LEN_W-1:0]  post_len,
    input  logic [DATA_W-1:0] adc_a,
    input  logic [DATA_W-1:0] adc_b,
    input  logic              ext_trig,
    input  logic              gen_evt,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data_a,
    output logic [DATA_W-1:0] wr_data_b,
    output logic [ADDR_W-1:0] wp_cur,
    output logic [ADDR_W-1:0] wp_trig,
    output logic [1:0]        cap_state,
    output logic              post_done
);

    logic                dec_valid;
    logic [2*DATA_W-1:0] dec_data;
    logic [2*DATA_W-1:0] wr_data;
    logic                fire;
    cap_state_e          st;

    cap_decimator #(.DATA_W(DATA_W), .NCH(2)) dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cmd_arm),
        .dec_code  (dec_code),
        .avg_en    (avg_en),
        .smp_in    ({adc_b, adc_a}),
        .dec_valid (dec_valid),
        .dec_data  (dec_data)
    );

    cap_trig_detect #(.DATA_W(DATA_W)) trg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cmd_arm),
        .trig_src  (trig_src),
        .thr_flat  ({thr_b, thr_a}),
        .hyst_flat ({hyst_b, hyst_a}),
        .dec_valid (dec_valid),
        .dec_data  (dec_data),
        .ext_trig  (ext_trig),
        .gen_evt   (gen_evt),
        .fire      (fire)
    );

    cap_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_arm   (cmd_arm),
        .cmd_reset (cmd_reset),
        .fire      (fire),
        .post_len  (post_len),
        .dec_valid (dec_valid),
        .dec_data  (dec_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wp_cur    (wp_cur),
        .wp_trig   (wp_trig),
        .state     (st)
    );

    assign wr_data_a = wr_data[DATA_W-1:0];
    assign wr_data_b = wr_data[2*DATA_W-1:DATA_W];
    assign cap_state = st;
    assign post_done = (st == ST_DONE);

endmodule

// File: rtl/trig_capture_chk.sv
// Protocol checker for trig_capture, attached through bind.
// Assumes: commands are single-cycle pulses.
module trig_capture_chk
    import cap_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_arm,
    input logic              cmd_reset,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] wp_cur,
    input logic [ADDR_W-1:0] wp_trig,
    input logic [1:0]        cap_state
);

    // A write strobe follows a cycle spent capturing (R5).
    assert_write_in_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(cap_state) == ST_ARMED || $past(cap_state) == ST_POST));

    // Writes land where the pointer stood (R5).
    assert_write_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr == $past(wp_cur)));

    // An arm restarts capture at address zero (R5).
    assert_arm_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_arm && !cmd_reset) |-> (cap_state == ST_ARMED && wp_cur == '0));

    // The reset command wins and silences the write port (R11).
    assert_reset_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_reset) |-> (cap_state == ST_IDLE && !wr_en));

    // The trigger pointer does not move once past the trigger (R6).
    assert_single_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == ST_POST && $past(cap_state) == ST_POST) |-> $stable(wp_trig));

    // No writes after the post-trigger count has run out (R10).
    assert_done_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == ST_DONE && $past(cap_state) == ST_DONE) |-> !wr_en);

endmodule

bind trig_capture trig_capture_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_arm   (cmd_arm),
    .cmd_reset (cmd_reset),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wp_cur    (wp_cur),
    .wp_trig   (wp_trig),
    .cap_state (cap_state)
);

// File: tb/trig_capture_tb_top.sv
// Self-checking bench: a behavioural reference model updated on every rising
// edge and compared with the design on every falling edge.
module trig_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_arm = 1'b0, cmd_reset = 1'b0;
    logic [3:0]  trig_src = 4'd15;
    logic [2:0]  dec_code = 3'd0;
    logic        avg_en = 1'b0;
    logic [13:0] thr_a = '0, thr_b = '0, hyst_a = '0, hyst_b = '0;
    logic [31:0] post_len = '0;
    logic [13:0] adc_a = '0, adc_b = '0;
    logic        ext_trig = 1'b0, gen_evt = 1'b0;
    logic        wr_en, post_done;
    logic [13:0] wr_addr, wr_data_a, wr_data_b, wp_cur, wp_trig;
    logic [1:0]  cap_state;

    always #2 clk = ~clk;

    trig_capture dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_arm(cmd_arm), .cmd_reset(cmd_reset),
        .trig_src(trig_src), .dec_code(dec_code), .avg_en(avg_en),
        .thr_a(thr_a), .thr_b(thr_b), .hyst_a(hyst_a), .hyst_b(hyst_b),
        .post_len(post_len), .adc_a(adc_a), .adc_b(adc_b),
        .ext_trig(ext_trig), .gen_evt(gen_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data_a(wr_data_a), .wr_data_b(wr_data_b),
        .wp_cur(wp_cur), .wp_trig(wp_trig), .cap_state(cap_state), .post_done(post_done)
    );

    int    checks = 0, errors = 0, cyc = 0;
    string cur_req = "R1";
    int    pat = 0, cval_a = 0, cval_b = 0, tri_v = 0, tri_dir = 1;
    logic [15:0] lfsr = 16'hACE1;
    int    last_wa = 0, last_wb = 0;

    task automatic check(input string req, input bit ok, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // ADC stimulus patterns: 0 constant, 1 triangle (B is the negated A), 2 pseudo-random.
    always @(negedge clk) begin
        lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tri_v <= tri_v + 97 * tri_dir;
        if (tri_v > 3000)  tri_dir <= -1;
        if (tri_v < -3000) tri_dir <= 1;
        case (pat)
            0: begin adc_a <= 14'(cval_a); adc_b <= 14'(cval_b); end
            1: begin adc_a <= 14'(tri_v);  adc_b <= 14'(-tri_v); end
            default: begin adc_a <= lfsr[13:0]; adc_b <= lfsr[15:2]; end
        endcase
    end

    // Reference model state.
    bit     m_go = 0;
    int     m_st = 0, m_wp = 0, m_wpt = 0, m_waddr = 0, m_wa = 0, m_wb = 0;
    bit     m_wr = 0, m_dv = 0;
    longint m_rem = 0, m_acca = 0, m_accb = 0;
    int     m_cnt = 0, m_da = 0, m_db = 0;
    bit     m_au = 0, m_ad = 0, m_bu = 0, m_bd = 0;
    bit     m_e1 = 0, m_e2 = 0, m_e3 = 0, m_g1 = 0, m_g2 = 0;

    function automatic int ratio_of(input int code);
        case (code)
            1: return 8;
            2: return 64;
            3: return 1024;
            4: return 8192;
            5: return 65536;
            default: return 1;
        endcase
    endfunction

    function automatic bit next_up(input bit rdy, input int s, input int t, input int h);
        if (s <= t - h) return 1'b1;
        if (s >= t)     return 1'b0;
        return rdy;
    endfunction

    function automatic bit next_dn(input bit rdy, input int s, input int t, input int h);
        if (s >= t + h) return 1'b1;
        if (s <= t)     return 1'b0;
        return rdy;
    endfunction

    // Reference model: advance one clock from the requirements.
    always @(posedge clk) begin : model
        int ta, tb, ha, hb, st0, wp0, ratio, k, xa, xb;
        bit fire;
        m_go = 1;
        if (!rst_n) begin
            m_st = 0; m_wp = 0; m_wpt = 0; m_wr = 0; m_dv = 0; m_rem = 0;
            m_acca = 0; m_accb = 0; m_cnt = 0; m_da = 0; m_db = 0;
            m_au = 0; m_ad = 0; m_bu = 0; m_bd = 0;
            m_e1 = 0; m_e2 = 0; m_e3 = 0; m_g1 = 0; m_g2 = 0;
        end else begin
            ta = $signed(thr_a); tb = $signed(thr_b);
            ha = int'(hyst_a);   hb = int'(hyst_b);
            xa = $signed(adc_a); xb = $signed(adc_b);
            case (trig_src)
                4'd0: fire = 1;
                4'd1: fire = m_dv && m_au && (m_da >= ta);
                4'd2: fire = m_dv && m_ad && (m_da <= ta);
                4'd3: fire = m_dv && m_bu && (m_db >= tb);
                4'd4: fire = m_dv && m_bd && (m_db <= tb);
                4'd5: fire = m_e2 && !m_e3;
                4'd6: fire = !m_e2 && m_e3;
                4'd7: fire = m_g1 && !m_g2;
                4'd8: fire = !m_g1 && m_g2;
                default: fire = 0;
            endcase
            st0 = m_st; wp0 = m_wp; m_wr = 0;
            if (cmd_reset) m_st = 0;
            else if (cmd_arm) begin m_st = 1; m_wp = 0; m_wpt = 0; end
            else begin
                if ((st0 == 1 || st0 == 2) && m_dv) begin
                    m_wr = 1; m_waddr = wp0; m_wa = m_da; m_wb = m_db;
                    m_wp = (wp0 + 1) % 16384;
                end
                if (st0 == 1 && fire) begin
                    m_wpt = wp0;
                    if (post_len == 0) m_st = 3;
                    else begin m_rem = longint'(post_len); m_st = 2; end
                end else if (st0 == 2 && m_dv) begin
                    if (m_rem == 1) m_st = 3;
                    m_rem--;
                end
            end
            if (cmd_arm) begin
                m_au = 0; m_ad = 0; m_bu = 0; m_bd = 0;
            end else if (m_dv) begin
                m_au = next_up(m_au, m_da, ta, ha); m_ad = next_dn(m_ad, m_da, ta, ha);
                m_bu = next_up(m_bu, m_db, tb, hb); m_bd = next_dn(m_bd, m_db, tb, hb);
            end
            ratio = ratio_of(int'(dec_code));
            if (cmd_arm) begin
                m_cnt = 0; m_acca = 0; m_accb = 0; m_dv = 0;
            end else if (m_cnt == ratio - 1) begin
                k = $clog2(ratio);
                m_da = avg_en ? int'((m_acca + xa) >>> k) : xa;
                m_db = avg_en ? int'((m_accb + xb) >>> k) : xb;
                m_dv = 1; m_cnt = 0; m_acca = 0; m_accb = 0;
            end else begin
                m_acca += xa; m_accb += xb; m_cnt++; m_dv = 0;
            end
            m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_trig;
            m_g2 = m_g1; m_g1 = gen_evt;
        end
    end

    // Compare the design with the model on every clock.
    always @(negedge clk) begin
        if (m_go) begin
            check(cur_req, wr_en === m_wr, "wr_en", wr_en, m_wr);
            check(cur_req, cap_state === 2'(m_st), "cap_state", cap_state, m_st);
            check(cur_req, post_done === (m_st == 3), "post_done", post_done, m_st == 3);
            check(cur_req, wp_cur === 14'(m_wp), "wp_cur", wp_cur, m_wp);
            check(cur_req, wp_trig === 14'(m_wpt), "wp_trig", wp_trig, m_wpt);
            if (m_wr) begin
                check(cur_req, wr_addr === 14'(m_waddr), "wr_addr", wr_addr, m_waddr);
                check(cur_req, $signed(wr_data_a) == m_wa, "wr_data_a", $signed(wr_data_a), m_wa);
                check(cur_req, $signed(wr_data_b) == m_wb, "wr_data_b", $signed(wr_data_b), m_wb);
            end
            if (wr_en === 1'b1) begin
                last_wa = $signed(wr_data_a);
                last_wb = $signed(wr_data_b);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL %s watchdog act=%0d exp=%0d", cur_req, cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic start(input string req, input int src, input int code, input bit avg,
                         input longint post);
        @(negedge clk);
        cur_req  = req;
        trig_src = 4'(src); dec_code = 3'(code); avg_en = avg; post_len = 32'(post);
        @(negedge clk); cmd_arm = 1'b1;
        @(negedge clk); cmd_arm = 1'b0;
    endtask

    task automatic wait_done(input int maxcyc);
        int n = 0;
        while (post_done !== 1'b1 && n < maxcyc) begin @(negedge clk); n++; end
        check(cur_req, post_done === 1'b1, "capture completion", post_done, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic stop();
        @(negedge clk); cmd_reset = 1'b1;
        @(negedge clk); cmd_reset = 1'b0;
        check("R11", cap_state == 2'd0 && wr_en == 1'b0, "idle after reset cmd", cap_state, 0);
    endtask

    task automatic pulse_ext(input int wait_c, input int len);
        repeat (wait_c) @(negedge clk); ext_trig = 1'b1;
        repeat (len) @(negedge clk);    ext_trig = 1'b0;
    endtask

    task automatic pulse_gen(input int wait_c, input int len);
        repeat (wait_c) @(negedge clk); gen_evt = 1'b1;
        repeat (len) @(negedge clk);    gen_evt = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1", wr_en == 0 && wp_cur == 0 && wp_trig == 0 && post_done == 0 && cap_state == 0,
              "outputs in reset", {wr_en, wp_cur, wp_trig}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", cap_state == 0 && wr_en == 0, "idle after reset", cap_state, 0);

        // Last-sample decimation, ratio 8 and ratio 1 through an out-of-range code.
        pat = 1;
        start("R3", 0, 1, 0, 20); wait_done(400); stop();
        pat = 2;
        start("R2", 0, 6, 0, 7);  wait_done(100); stop();

        // Averaging at ratios 64 and 1024.
        start("R4", 0, 2, 1, 10); wait_done(1500); stop();
        start("R4", 0, 3, 1, 3);  wait_done(5000); stop();

        // Level triggers with hysteresis.
        pat = 1; thr_a = 14'(1000); hyst_a = 14'(200);
        start("R7", 1, 0, 0, 30); wait_done(600); stop();
        thr_b = 14'(-500); hyst_b = 14'(100);
        start("R8", 4, 1, 0, 6);  wait_done(2000); stop();
        thr_b = 14'(200); hyst_b = 14'(0);
        start("R7", 3, 0, 1, 12); wait_done(600); stop();
        thr_a = 14'(-1500); hyst_a = 14'(300);
        start("R8", 2, 0, 0, 12); wait_done(600); stop();

        // External pin and generator event edges.
        start("R9", 5, 0, 0, 5); pulse_ext(20, 10); wait_done(100); stop();
        start("R9", 6, 0, 0, 5); pulse_ext(20, 10); wait_done(100); stop();
        start("R9", 7, 0, 0, 5); pulse_gen(15, 6);  wait_done(100); stop();
        start("R9", 8, 0, 0, 5); pulse_gen(15, 6);  wait_done(100); stop();

        // Triggers before an arm and after the first accepted one are ignored.
        pulse_ext(2, 6); repeat (6) @(negedge clk);
        start("R6", 5, 0, 0, 40);
        repeat (30) @(negedge clk);
        check("R6", cap_state == 2'd1, "still armed", cap_state, 1);
        pulse_ext(0, 4); pulse_ext(8, 4);
        wait_done(100); stop();

        // Post length zero: done straight from the trigger cycle.
        start("R10", 5, 0, 0, 0); pulse_ext(10, 3); wait_done(50);
        check("R10", wr_en == 0, "no write in done", wr_en, 0);
        stop();

        // No trigger source: pointer wraps through the whole buffer.
        start("R12", 12, 0, 0, 1);
        repeat (16500) @(negedge clk);
        check("R12", cap_state == 2'd1, "never triggered", cap_state, 1);
        cur_req = "R5";
        repeat (20) @(negedge clk);
        stop();

        // Reset command beats a simultaneous arm.
        @(negedge clk); cur_req = "R11"; cmd_arm = 1'b1; cmd_reset = 1'b1;
        @(negedge clk); cmd_arm = 1'b0; cmd_reset = 1'b0;
        check("R11", cap_state == 2'd0, "reset priority", cap_state, 0);

        // Full-scale averaging over the longest window.
        pat = 0; cval_a = 8191; cval_b = -8192;
        start("R4", 0, 5, 1, 1); wait_done(70000);
        check("R4", last_wa == 8191, "mean A at 65536", last_wa, 8191);
        check("R4", last_wb == -8192, "mean B at 65536", last_wb, -8192);
        stop();

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule